// File: doc/BRIEF.md
# Multi-Bank Flash Command Decoder

This block sits behind the write port of a banked NOR-style flash memory and interprets each bus write as part of a command. Single-write codes change how one bank answers reads: plain array data, the status register, the electronic signature, or the CFI query table. Setup codes followed by a matching confirm code start a program, erase, lock, configuration, blank-check or protection operation on an external program/erase engine. That engine appears here only as a start pulse out and a done/fail pair in.

Each bank keeps its own read mode, so a bank can be switched to status or array reads while another bank is being programmed. A bank stays flagged as not holding valid data while an operation runs on it. The status register shows a ready bit, a suspended bit and sticky error bits. A copy of it is captured on the falling edge of chip enable or output enable and is held between those edges. Only one engine operation is active at a time.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset every bank is in array mode (`bank_mode` all zero), `bank_ok` is all ones, no pulse is active and the first captured status is 8'h80.
- R2: With no setup pending, a write of FFh, 70h, 98h or 90h sets the mode field `bank_mode[2b+1:2b]` of the addressed bank `b` to 0 (array), 1 (status), 3 (CFI) or 2 (signature). The fields of the other banks keep their values.
- R3: A setup code followed by its confirm code raises `op_start` for one cycle, in the cycle after the confirm write. `op_bank` is set to the confirm write's bank. `op_kind` is 2 for 20h/D0h, 3 for 60h/01h, 4 for 60h/D0h, 5 for 60h/2Fh, 6 for 60h/03h, 7 for E8h/D0h, 8 for 80h/D0h and 9 for BCh/CBh.
- R4: After 40h or 10h, the next write of any value starts a word program (`op_kind` 1). After C0h, the next write starts a protection program (`op_kind` 10).
- R5: A write after a setup code that is not that setup's confirm cancels the sequence. It starts nothing and has no other effect, even when its value is a command code.
- R6: A setup code written while an operation is active starts nothing, leaves no sequence pending and sets status bit 3.
- R7: Read-mode commands are accepted while an operation is active. `bank_ok[b]` is low exactly while an operation started on bank `b` has not completed.
- R8: `status_view` takes the live status on each clock edge where `ce_n` or `oe_n` is sampled low after being high. It holds its value on every other edge.
- R9: A 90h write is refused, and changes no bank mode, while a protection program (kind 10) is active.
- R10: `pec_done` with `pec_fail` high during an operation sets status bit 4. A 50h write clears bits 4 and 3. If both happen in the same cycle, the set wins.
- R11: B0h while an operation is active, not suspended and not completing this cycle raises `susp_pulse` and sets status bit 6. D0h with no setup pending while suspended raises `resume_pulse` and clears bit 6. Completion also clears bit 6.
- R12: Status bit 7 (ready) is low from the edge that raises `op_start` until the edge that samples `pec_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_bank | input | BANK_W | Bank-select bits of the write address |
| wr_data | input | 8 | Command or data byte |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pec_done | input | 1 | Engine finished the active operation |
| pec_fail | input | 1 | Qualifies pec_done: operation failed |
| op_start | output | 1 | One-cycle start pulse to the engine |
| op_kind | output | 4 | Kind of the started operation |
| op_bank | output | BANK_W | Bank of the started operation |
| susp_pulse | output | 1 | One-cycle suspend request |
| resume_pulse | output | 1 | One-cycle resume request |
| bank_mode | output | 2*NBANK | Read-source selection, two bits per bank |
| bank_ok | output | NBANK | Per-bank read data valid |
| status_view | output | 8 | Status register as captured for reads |

## Verification
The assertions assume that the engine raises `pec_done` only for an operation that was started and that `wr_bank` addresses an existing bank. The random stimulus issues done only while the bench's model holds an operation active, and draws banks only below NBANK. The stimulus mixes valid command codes with arbitrary bytes and toggles chip and output enable at random. It therefore reaches mismatched confirms, setups sent while busy, suspends that coincide with completion, and status captures in the same cycle as state changes.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_SIG    = 2'd2,
    RM_CFI    = 2'd3
  } rmode_t;

  localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_RD_STAT  = 8'h70;
  localparam logic [7:0] CMD_RD_SIG   = 8'h90;
  localparam logic [7:0] CMD_RD_CFI   = 8'h98;
  localparam logic [7:0] CMD_CLR      = 8'h50;
  localparam logic [7:0] CMD_SUSP     = 8'hB0;
  localparam logic [7:0] CMD_GO       = 8'hD0;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_LOCKGRP  = 8'h60;
  localparam logic [7:0] CMD_PROG     = 8'h40;
  localparam logic [7:0] CMD_PROG_ALT = 8'h10;
  localparam logic [7:0] CMD_BUF      = 8'hE8;
  localparam logic [7:0] CMD_EBUF     = 8'h80;
  localparam logic [7:0] CMD_BLANK    = 8'hBC;
  localparam logic [7:0] CMD_PROT     = 8'hC0;
  localparam logic [7:0] CMD_LOCK_OK  = 8'h01;
  localparam logic [7:0] CMD_LKDN_OK  = 8'h2F;
  localparam logic [7:0] CMD_CFG_OK   = 8'h03;
  localparam logic [7:0] CMD_BLANK_OK = 8'hCB;

  localparam logic [3:0] OPK_NONE   = 4'd0;
  localparam logic [3:0] OPK_PROG   = 4'd1;
  localparam logic [3:0] OPK_ERASE  = 4'd2;
  localparam logic [3:0] OPK_LOCK   = 4'd3;
  localparam logic [3:0] OPK_UNLOCK = 4'd4;
  localparam logic [3:0] OPK_LKDN   = 4'd5;
  localparam logic [3:0] OPK_CFG    = 4'd6;
  localparam logic [3:0] OPK_BUF    = 4'd7;
  localparam logic [3:0] OPK_EBUF   = 4'd8;
  localparam logic [3:0] OPK_BLANK  = 4'd9;
  localparam logic [3:0] OPK_PROT   = 4'd10;

  // codes that open a two-write sequence
  function automatic logic is_setup(input logic [7:0] c);
    return c inside {CMD_PROG, CMD_PROG_ALT, CMD_PROT, CMD_ERASE,
                     CMD_LOCKGRP, CMD_BUF, CMD_EBUF, CMD_BLANK};
  endfunction

  // operation kind for a pending setup and the write that follows it
  function automatic logic [3:0] confirm_op(input logic [7:0] s, input logic [7:0] c);
    logic [3:0] k;
    k = OPK_NONE;
    case (s)
      CMD_PROG, CMD_PROG_ALT: k = OPK_PROG;
      CMD_PROT:               k = OPK_PROT;
      CMD_ERASE:              if (c == CMD_GO) k = OPK_ERASE;
      CMD_BUF:                if (c == CMD_GO) k = OPK_BUF;
      CMD_EBUF:               if (c == CMD_GO) k = OPK_EBUF;
      CMD_BLANK:              if (c == CMD_BLANK_OK) k = OPK_BLANK;
      CMD_LOCKGRP: begin
        case (c)
          CMD_LOCK_OK: k = OPK_LOCK;
          CMD_GO:      k = OPK_UNLOCK;
          CMD_LKDN_OK: k = OPK_LKDN;
          CMD_CFG_OK:  k = OPK_CFG;
          default:     k = OPK_NONE;
        endcase
      end
      default: k = OPK_NONE;
    endcase
    return k;
  endfunction

  function automatic rmode_t mode_of(input logic [7:0] c);
    case (c)
      CMD_RD_STAT: return RM_STATUS;
      CMD_RD_SIG:  return RM_SIG;
      CMD_RD_CFI:  return RM_CFI;
      default:     return RM_ARRAY;
    endcase
  endfunction

  // bit 7 ready, 6 suspended, 4 operation failed, 3 sequence error
  function automatic logic [7:0] status_byte(input logic ready, input logic susp,
                                             input logic fail, input logic serr);
    return {ready, susp, 1'b0, fail, serr, 3'b000};
  endfunction

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       active,
  input  logic       susp,
  input  logic       prot_run,
  input  logic       pec_done,
  output logic       mode_req,
  output rmode_t     mode_val,
  output logic       start_req,
  output logic [3:0] start_kind,
  output logic       clear_req,
  output logic       susp_req,
  output logic       resume_req,
  output logic       setup_busy,
  output logic       sig_blocked
);

  logic       pend_v;
  logic [7:0] pend_q;
  logic       setup_take;

  always_comb begin
    mode_req    = 1'b0;
    mode_val    = mode_of(wr_data);
    start_req   = 1'b0;
    start_kind  = OPK_NONE;
    clear_req   = 1'b0;
    susp_req    = 1'b0;
    resume_req  = 1'b0;
    setup_busy  = 1'b0;
    setup_take  = 1'b0;
    sig_blocked = 1'b0;
    if (wr_en) begin
      if (pend_v) begin
        start_kind = confirm_op(pend_q, wr_data);
        start_req  = (start_kind != OPK_NONE);
      end else begin
        case (wr_data)
          CMD_RD_ARRAY, CMD_RD_STAT, CMD_RD_CFI: mode_req = 1'b1;
          CMD_RD_SIG: begin
            sig_blocked = prot_run;
            mode_req    = !prot_run;
          end
          CMD_CLR:  clear_req  = 1'b1;
          CMD_SUSP: susp_req   = active && !susp && !pec_done;
          CMD_GO:   resume_req = susp;
          default: begin
            if (is_setup(wr_data)) begin
              setup_busy = active;
              setup_take = !active;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_q <= 8'h00;
    end else if (wr_en) begin
      if (pend_v) begin
        pend_v <= 1'b0;
      end else if (setup_take) begin
        pend_v <= 1'b1;
        pend_q <= wr_data;
      end
    end
  end

endmodule

// File: rtl/fcd_bank_modes.sv
module fcd_bank_modes
  import fcd_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int BANK_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_req,
  input  rmode_t              mode_val,
  input  logic [BANK_W-1:0]   wr_bank,
  input  logic                active,
  input  logic [BANK_W-1:0]   op_bank,
  output logic [2*NBANK-1:0]  bank_mode,
  output logic [NBANK-1:0]    bank_ok
);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    rmode_t m_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        m_q <= RM_ARRAY;
      else if (mode_req && wr_bank == BANK_W'(b))
        m_q <= mode_val;
    end
    assign bank_mode[2*b +: 2] = m_q;
    assign bank_ok[b]          = !(active && op_bank == BANK_W'(b));
  end

endmodule

// File: rtl/fcd_status.sv
module fcd_status
  import fcd_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [3:0]        start_kind,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic              pec_done,
  input  logic              pec_fail,
  input  logic              clear_req,
  input  logic              susp_req,
  input  logic              resume_req,
  input  logic              setup_busy,
  input  logic              ce_n,
  input  logic              oe_n,
  output logic              op_start,
  output logic [3:0]        op_kind,
  output logic [BANK_W-1:0] op_bank,
  output logic              active,
  output logic              susp,
  output logic              prot_run,
  output logic [7:0]        status_view,
  output logic              status_cap,
  output logic              susp_pulse,
  output logic              resume_pulse
);

  logic       fail_b, serr_b, ce_q, oe_q;
  logic [7:0] live;

  assign live       = status_byte(!active, susp, fail_b, serr_b);
  assign status_cap = (ce_q && !ce_n) || (oe_q && !oe_n);
  assign prot_run   = active && (op_kind == OPK_PROT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active       <= 1'b0;
      op_kind      <= OPK_NONE;
      op_bank      <= '0;
      susp         <= 1'b0;
      fail_b       <= 1'b0;
      serr_b       <= 1'b0;
      ce_q         <= 1'b1;
      oe_q         <= 1'b1;
      status_view  <= status_byte(1'b1, 1'b0, 1'b0, 1'b0);
      op_start     <= 1'b0;
      susp_pulse   <= 1'b0;
      resume_pulse <= 1'b0;
    end else begin
      ce_q         <= ce_n;
      oe_q         <= oe_n;
      op_start     <= start_req;
      susp_pulse   <= susp_req;
      resume_pulse <= resume_req;
      if (status_cap) status_view <= live;
      if (start_req) begin
        active  <= 1'b1;
        op_kind <= start_kind;
        op_bank <= wr_bank;
      end
      if (susp_req)   susp <= 1'b1;
      if (resume_req) susp <= 1'b0;
      if (clear_req) begin
        fail_b <= 1'b0;
        serr_b <= 1'b0;
      end
      if (setup_busy) serr_b <= 1'b1;
      // completion is applied last so that it wins over same-cycle writes
      if (pec_done && active) begin
        active <= 1'b0;
        susp   <= 1'b0;
        if (pec_fail) fail_b <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter  int NBANK  = 4,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [BANK_W-1:0]  wr_bank,
  input  logic [7:0]         wr_data,
  input  logic               ce_n,
  input  logic               oe_n,
  input  logic               pec_done,
  input  logic               pec_fail,
  output logic               op_start,
  output logic [3:0]         op_kind,
  output logic [BANK_W-1:0]  op_bank,
  output logic               susp_pulse,
  output logic               resume_pulse,
  output logic [2*NBANK-1:0] bank_mode,
  output logic [NBANK-1:0]   bank_ok,
  output logic [7:0]         status_view
);

  // internal events, named for the checker
  logic       mode_req, start_req, clear_req, susp_req, resume_req;
  logic       setup_busy, sig_blocked, status_cap;
  logic       active, susp, prot_run;
  logic [3:0] start_kind;
  rmode_t     mode_val;

  fcd_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .active     (active),
    .susp       (susp),
    .prot_run   (prot_run),
    .pec_done   (pec_done),
    .mode_req   (mode_req),
    .mode_val   (mode_val),
    .start_req  (start_req),
    .start_kind (start_kind),
    .clear_req  (clear_req),
    .susp_req   (susp_req),
    .resume_req (resume_req),
    .setup_busy (setup_busy),
    .sig_blocked(sig_blocked)
  );

  fcd_bank_modes #(.NBANK(NBANK), .BANK_W(BANK_W)) u_modes (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_req (mode_req),
    .mode_val (mode_val),
    .wr_bank  (wr_bank),
    .active   (active),
    .op_bank  (op_bank),
    .bank_mode(bank_mode),
    .bank_ok  (bank_ok)
  );

  fcd_status #(.BANK_W(BANK_W)) u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .start_kind  (start_kind),
    .wr_bank     (wr_bank),
    .pec_done    (pec_done),
    .pec_fail    (pec_fail),
    .clear_req   (clear_req),
    .susp_req    (susp_req),
    .resume_req  (resume_req),
    .setup_busy  (setup_busy),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .op_start    (op_start),
    .op_kind     (op_kind),
    .op_bank     (op_bank),
    .active      (active),
    .susp        (susp),
    .prot_run    (prot_run),
    .status_view (status_view),
    .status_cap  (status_cap),
    .susp_pulse  (susp_pulse),
    .resume_pulse(resume_pulse)
  );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int NBANK = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_start,
  input logic               active,
  input logic               susp,
  input logic               mode_req,
  input logic               sig_blocked,
  input logic               status_cap,
  input logic               susp_pulse,
  input logic               resume_pulse,
  input logic [7:0]         status_view,
  input logic [2*NBANK-1:0] bank_mode
);

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(!active)); // R6

  AST_START_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> active); // R12

  AST_VIEW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !status_cap |=> $stable(status_view)); // R8

  AST_MODES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_req |=> $stable(bank_mode)); // R2

  AST_SIG_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    sig_blocked |=> $stable(bank_mode)); // R9

  AST_SUSP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    susp_pulse |-> (active && susp)); // R11

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({susp_pulse, resume_pulse}) <= 1); // R11

endmodule

bind flash_cmd_decoder fcd_checker #(.NBANK(NBANK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_start    (op_start),
  .active      (active),
  .susp        (susp),
  .mode_req    (mode_req),
  .sig_blocked (sig_blocked),
  .status_cap  (status_cap),
  .susp_pulse  (susp_pulse),
  .resume_pulse(resume_pulse),
  .status_view (status_view),
  .bank_mode   (bank_mode)
);

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;

  localparam int NB = 4;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [BW-1:0] wr_bank;
  logic [7:0]    wr_data;
  logic          ce_n, oe_n, pec_done, pec_fail;
  logic          op_start, susp_pulse, resume_pulse;
  logic [3:0]    op_kind;
  logic [BW-1:0] op_bank;
  logic [2*NB-1:0] bank_mode;
  logic [NB-1:0] bank_ok;
  logic [7:0]    status_view;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder #(.NBANK(NB)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_data(wr_data),
    .ce_n(ce_n), .oe_n(oe_n), .pec_done(pec_done), .pec_fail(pec_fail),
    .op_start(op_start), .op_kind(op_kind), .op_bank(op_bank),
    .susp_pulse(susp_pulse), .resume_pulse(resume_pulse),
    .bank_mode(bank_mode), .bank_ok(bank_ok), .status_view(status_view)
  );

  // reference model state
  int         m_mode [NB];
  logic       m_pv, m_act, m_susp, m_fail, m_serr, m_ceq, m_oeq;
  logic       m_start, m_sp, m_rp;
  logic [7:0] m_pend, m_view;
  logic [3:0] m_kind;
  logic [BW-1:0] m_bank;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_kind(input logic [7:0] s, input logic [7:0] c);
    if (s == 8'h40 || s == 8'h10) return 4'd1;
    if (s == 8'hC0) return 4'd10;
    if (s == 8'hBC) return (c == 8'hCB) ? 4'd9 : 4'd0;
    if (s == 8'h60) begin
      if (c == 8'h01) return 4'd3;
      if (c == 8'h2F) return 4'd5;
      if (c == 8'h03) return 4'd6;
      if (c == 8'hD0) return 4'd4;
      return 4'd0;
    end
    if (c != 8'hD0) return 4'd0;
    if (s == 8'h20) return 4'd2;
    if (s == 8'hE8) return 4'd7;
    if (s == 8'h80) return 4'd8;
    return 4'd0;
  endfunction

  function automatic logic [2*NB-1:0] ref_modes();
    logic [2*NB-1:0] v;
    for (int i = 0; i < NB; i++) v[2*i +: 2] = m_mode[i][1:0];
    return v;
  endfunction

  function automatic logic [NB-1:0] ref_ok();
    logic [NB-1:0] v;
    for (int i = 0; i < NB; i++) v[i] = !(m_act && int'(m_bank) == i);
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NB; i++) m_mode[i] = 0;
    m_pv = 0; m_act = 0; m_susp = 0; m_fail = 0; m_serr = 0;
    m_ceq = 1; m_oeq = 1; m_start = 0; m_sp = 0; m_rp = 0;
    m_pend = 0; m_view = 8'h80; m_kind = 0; m_bank = 0;
  endtask

  task automatic model_step();
    logic [7:0] live;
    logic       was_act;
    logic [3:0] k;
    live    = {~m_act, m_susp, 1'b0, m_fail, m_serr, 3'b000};
    was_act = m_act;
    m_start = 0; m_sp = 0; m_rp = 0;
    if ((m_ceq && !ce_n) || (m_oeq && !oe_n)) m_view = live;
    m_ceq = ce_n; m_oeq = oe_n;
    if (wr_en) begin
      if (m_pv) begin
        m_pv = 0;
        k = ref_kind(m_pend, wr_data);
        if (k != 0) begin
          m_start = 1; m_kind = k; m_bank = wr_bank; m_act = 1;
        end
      end else begin
        case (wr_data)
          8'hFF: m_mode[wr_bank] = 0;
          8'h70: m_mode[wr_bank] = 1;
          8'h98: m_mode[wr_bank] = 3;
          8'h90: if (!(was_act && m_kind == 4'd10)) m_mode[wr_bank] = 2;
          8'h50: begin m_fail = 0; m_serr = 0; end
          8'hB0: if (was_act && !m_susp && !pec_done) begin m_susp = 1; m_sp = 1; end
          8'hD0: if (m_susp) begin m_susp = 0; m_rp = 1; end
          8'h40, 8'h10, 8'hC0, 8'h20, 8'h60, 8'hE8, 8'h80, 8'hBC: begin
            if (was_act) m_serr = 1;
            else begin m_pv = 1; m_pend = wr_data; end
          end
          default: ;
        endcase
      end
    end
    if (pec_done && was_act) begin
      m_act = 0; m_susp = 0;
      if (pec_fail) m_fail = 1;
    end
  endtask

  // one clock: drive now (at a falling edge), compare at the next falling edge
  task automatic cyc(input logic en, input logic [BW-1:0] b, input logic [7:0] d,
                     input logic dn, input logic fl, input logic ce, input logic oe);
    wr_en = en; wr_bank = b; wr_data = d; pec_done = dn; pec_fail = fl;
    ce_n = ce; oe_n = oe;
    model_step();
    @(negedge clk);
    chk(bank_mode == ref_modes(), "R2 bank_mode vs model", bank_mode, ref_modes());
    chk(bank_ok == ref_ok(), "R7 bank_ok vs model", bank_ok, ref_ok());
    chk(op_start == m_start, "R3 op_start vs model", op_start, m_start);
    if (m_start) begin
      chk(op_kind == m_kind, "R3 op_kind vs model", op_kind, m_kind);
      chk(op_bank == m_bank, "R3 op_bank vs model", op_bank, m_bank);
    end
    chk(status_view == m_view, "R8 status_view vs model", status_view, m_view);
    chk({susp_pulse, resume_pulse} == {m_sp, m_rp}, "R11 pulses vs model",
        {susp_pulse, resume_pulse}, {m_sp, m_rp});
  endtask

  task automatic wr(input logic [BW-1:0] b, input logic [7:0] d);
    cyc(1'b1, b, d, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic finish_op(input logic fl);
    cyc(1'b0, '0, 8'h00, 1'b1, fl, 1'b1, 1'b1);
  endtask

  task automatic read_status();
    cyc(1'b0, '0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic idle();
    cyc(1'b0, '0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  function automatic logic [7:0] pick_code(input int sel, input logic [7:0] rnd);
    case (sel)
      0: return 8'hFF;  1: return 8'h70;  2: return 8'h90;  3: return 8'h98;
      4: return 8'h50;  5: return 8'hB0;  6: return 8'hD0;  7: return 8'h20;
      8: return 8'h60;  9: return 8'h40; 10: return 8'h10; 11: return 8'hE8;
     12: return 8'h80; 13: return 8'hBC; 14: return 8'hC0; 15: return 8'h01;
     16: return 8'h2F; 17: return 8'h03; 18: return 8'hCB; 19: return 8'hD0;
      default: return rnd;
    endcase
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0101));
    rst_n = 0; wr_en = 0; wr_bank = 0; wr_data = 0;
    ce_n = 1; oe_n = 1; pec_done = 0; pec_fail = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();

    // R1: reset state
    chk(bank_mode == '0, "R1 bank_mode after reset", bank_mode, 0);
    chk(bank_ok == '1, "R1 bank_ok after reset", bank_ok, 4'hF);
    chk(!op_start && !susp_pulse && !resume_pulse, "R1 no pulses after reset",
        {op_start, susp_pulse, resume_pulse}, 0);
    read_status();
    chk(status_view == 8'h80, "R1 first captured status", status_view, 8'h80);
    idle();

    // R2: per-bank read modes
    wr(2, 8'h70);
    chk(bank_mode == 8'h10, "R2 70h bank 2", bank_mode, 8'h10);
    wr(0, 8'h98);
    chk(bank_mode == 8'h13, "R2 98h bank 0", bank_mode, 8'h13);
    wr(3, 8'h90);
    chk(bank_mode == 8'h93, "R2 90h bank 3", bank_mode, 8'h93);
    wr(2, 8'hFF);
    chk(bank_mode == 8'h83, "R2 FFh bank 2", bank_mode, 8'h83);

    // R3, R7, R6, R12, R10: erase on bank 1
    wr(1, 8'h20);
    wr(1, 8'hD0);
    chk(op_start && op_kind == 4'd2 && op_bank == 2'd1, "R3 erase start",
        {op_start, op_kind, op_bank}, {1'b1, 4'd2, 2'd1});
    chk(bank_ok == 4'b1101, "R7 busy bank flagged", bank_ok, 4'b1101);
    wr(1, 8'h70);
    chk(bank_mode == 8'h87, "R7 mode change while busy", bank_mode, 8'h87);
    wr(0, 8'h40);
    chk(!op_start, "R6 setup while busy starts nothing", op_start, 0);
    wr(0, 8'h12);
    chk(!op_start, "R6 no pending after refused setup", op_start, 0);
    read_status(); idle();
    chk(status_view == 8'h08, "R12 ready low and R6 error bit", status_view, 8'h08);
    finish_op(1'b1);
    chk(bank_ok == 4'hF, "R7 bank valid after done", bank_ok, 4'hF);
    read_status(); idle();
    chk(status_view == 8'h98, "R10 fail bit set", status_view, 8'h98);
    wr(0, 8'h50);
    read_status(); idle();
    chk(status_view == 8'h80, "R10 clear status", status_view, 8'h80);

    // R5: mismatched confirm is swallowed
    wr(0, 8'h60);
    wr(0, 8'h70);
    chk(!op_start && bank_mode == 8'h87, "R5 mismatch ignored",
        {op_start, bank_mode}, {1'b0, 8'h87});
    wr(0, 8'hD0);
    chk(!op_start && !resume_pulse, "R5 sequence cancelled", {op_start, resume_pulse}, 0);
    wr(3, 8'h60);
    wr(3, 8'h01);
    chk(op_start && op_kind == 4'd3 && op_bank == 2'd3, "R3 lock start",
        {op_start, op_kind, op_bank}, {1'b1, 4'd3, 2'd3});
    finish_op(1'b0);

    // R4, R9: word program and protection program
    wr(2, 8'h10);
    wr(2, 8'h3C);
    chk(op_start && op_kind == 4'd1 && op_bank == 2'd2, "R4 word program start",
        {op_start, op_kind, op_bank}, {1'b1, 4'd1, 2'd2});
    finish_op(1'b0);
    wr(0, 8'hC0);
    wr(0, 8'h55);
    chk(op_start && op_kind == 4'd10, "R4 protection program start",
        {op_start, op_kind}, {1'b1, 4'd10});
    wr(0, 8'h90);
    chk(bank_mode == 8'h87, "R9 signature refused", bank_mode, 8'h87);
    finish_op(1'b0);
    wr(0, 8'h90);
    chk(bank_mode == 8'h86, "R9 signature accepted after", bank_mode, 8'h86);

    // R11: suspend and resume
    wr(3, 8'hE8);
    wr(3, 8'hD0);
    chk(op_start && op_kind == 4'd7, "R3 buffer program start", {op_start, op_kind}, {1'b1, 4'd7});
    wr(3, 8'hB0);
    chk(susp_pulse, "R11 suspend pulse", susp_pulse, 1);
    read_status(); idle();
    chk(status_view == 8'h40, "R11 suspended bit", status_view, 8'h40);
    wr(3, 8'hD0);
    chk(resume_pulse && !op_start, "R11 resume pulse", {resume_pulse, op_start}, 2'b10);
    finish_op(1'b0);

    // R8: view holds without an enable edge, updates on ce_n fall
    wr(0, 8'hBC);
    wr(0, 8'hCB);
    chk(op_kind == 4'd9 && status_view == 8'h40, "R8 view held",
        {op_kind, status_view}, {4'd9, 8'h40});
    cyc(1'b0, '0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(status_view == 8'h00, "R8 capture on ce_n fall", status_view, 8'h00);
    cyc(1'b0, '0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    finish_op(1'b0);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      logic en, dn, fl, ce, oe;
      logic [BW-1:0] b;
      logic [7:0] d;
      en = ($urandom % 10) < 6;
      b  = BW'($urandom % NB);
      d  = pick_code(int'($urandom % 24), 8'($urandom));
      dn = m_act && (($urandom % 6) == 0);
      fl = dn && (($urandom % 3) == 0);
      ce = ($urandom % 4) != 0;
      oe = ($urandom % 3) != 0;
      cyc(en, b, d, dn, fl, ce, oe);
    end

    summary();
    $finish;
  end

endmodule